// File: doc/BRIEF.md
# Two-Counter Programmable-Period PWM Generator

This block produces a pulse-width-modulated output whose period and low-phase width are both set by software. It uses two up-counters that advance on one shared count tick. The period counter fixes the length of each cycle. The low-phase counter fixes how long the output stays low at the start of that cycle, after which the output goes high until the period ends. Both counters take their limits from compare latches, never directly from the data registers. A new value therefore cannot disturb the cycle in progress.

The surrounding logic writes the two data registers through a shared write-data bus with one strobe per register. It holds `run_i` high to let the generator run and feeds `tick_i` from whatever prescaler it uses. Each counter raises a sticky match flag. Each flag has its own enable and its own write-one-to-clear input, and the enabled flags are OR-ed into one interrupt line.

Top module: `dcpwm_top`

## Requirements
- R1: While running, the counters, the output and the match flags change only in a clock cycle where `tick_i` is 1. A clock without a tick leaves `pwm_o` and both flags unchanged, except for flag clears.
- R2: With period latch P and low-width latch L, where 1 <= L <= P, a cycle lasts P+1 ticks. `pwm_o` is low for the first L ticks and high for the remaining P+1-L ticks.
- R3: Every cycle, including the first one after start, begins with `pwm_o` low when its low-width latch is non-zero. No initial-level setting exists that could change this.
- R4: A low-width latch of 0 drives `pwm_o` high for the whole cycle.
- R5: A low-width latch greater than the period latch keeps `pwm_o` low for the whole cycle.
- R6: Each compare latch loads from its data register when counting starts and at each match of its counter. A data register written while running changes nothing until the next period match, and from that cycle on it governs.
- R7: `per_flag_o` sets on a period match. `low_flag_o` sets when the low-width counter reaches its latch, or at the start of a cycle whose low width is 0. Each flag stays set until its clear input is 1. A set in the same cycle as a clear wins.
- R8: `irq_o` is 1 exactly when some flag is set and its enable input is 1.
- R9: While `run_i` is 0, `pwm_o` holds its last level and ticks have no effect on the output or the flags.
- R10: Raising `run_i` reloads both latches from the data registers and starts a new cycle from count 0. The tick in that start cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 runs the generator; a rising level starts it |
| tick_i | input | 1 | Count enable shared by both counters |
| per_wr_i | input | 1 | Write strobe for the period data register |
| low_wr_i | input | 1 | Write strobe for the low-width data register |
| wr_data_i | input | W (8) | Write data for both data registers |
| per_ie_i | input | 1 | Interrupt enable for the period flag |
| low_ie_i | input | 1 | Interrupt enable for the low-width flag |
| per_clr_i | input | 1 | Write-one-to-clear for the period flag |
| low_clr_i | input | 1 | Write-one-to-clear for the low-width flag |
| pwm_o | output | 1 | PWM waveform |
| per_flag_o | output | 1 | Sticky period-match flag |
| low_flag_o | output | 1 | Sticky low-width-match flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
Any internal state error shows on `pwm_o` within one cycle of the waveform. A stale or early-loaded latch moves the rising edge, or the period match, by at least one tick in the cycle after a mid-run write. A counter that advances without a tick shows up at the next clock as an output or flag change between ticks. The bench compares `pwm_o`, both flags and `irq_o` in every clock cycle against an index-based model of the waveform. A wrong count, phase or latch value is therefore caught at the first clock where it changes a port.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;

    // Default counter width
    localparam int unsigned CNT_W = 8;

    // Channel indices into the per-channel arrays
    localparam int unsigned CH_PER = 0;
    localparam int unsigned CH_LOW = 1;
    localparam int unsigned N_CH   = 2;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_STOP = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Events produced by the sequencer in one clock
    typedef struct packed {
        logic start;    // counting begins
        logic step;     // a counted tick
        logic per_hit;  // period counter reached its latch
        logic low_hit;  // low counter reached its latch
    } seq_evt_t;

    // True when a low-width value asks for a cycle with no low phase
    function automatic logic no_low_phase(input logic [CNT_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/dcpwm_shadow.sv
module dcpwm_shadow #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] reg_q,
    output logic [W-1:0] lat_q
);

    // Data register written by software
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= wr_data;
        end
    end

    // Compare latch: takes the register value as it stood before this clock
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (load) begin
            lat_q <= reg_q;
        end
    end

endmodule

// File: rtl/dcpwm_counter.sv
module dcpwm_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dcpwm_flags.sv
module dcpwm_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flag_q,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (set[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign irq = |(flag_q & en);

endmodule

// File: rtl/dcpwm_top.sv
module dcpwm_top
    import dcpwm_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         per_wr_i,
    input  logic         low_wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         per_ie_i,
    input  logic         low_ie_i,
    input  logic         per_clr_i,
    input  logic         low_clr_i,
    output logic         pwm_o,
    output logic         per_flag_o,
    output logic         low_flag_o,
    output logic         irq_o
);

    localparam int unsigned XW = W + 1;

    // Per-channel arrays, indexed by CH_PER / CH_LOW
    logic         shd_wr   [N_CH];
    logic         shd_load [N_CH];
    logic [W-1:0] shd_reg  [N_CH];
    logic [W-1:0] shd_lat  [N_CH];
    logic         cnt_clr  [N_CH];
    logic         cnt_inc  [N_CH];
    logic [W-1:0] cnt_val  [N_CH];

    phase_e       phase_q, phase_d;
    seq_evt_t     ev;
    logic         pwm_q, pwm_d;
    logic         next_high;   // cycle being (re)started has no low phase
    logic [XW-1:0] low_nxt;

    assign shd_wr[CH_PER] = per_wr_i;
    assign shd_wr[CH_LOW] = low_wr_i;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dcpwm_shadow #(.W(W)) u_shadow (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (shd_wr[c]),
            .wr_data(wr_data_i),
            .load   (shd_load[c]),
            .reg_q  (shd_reg[c]),
            .lat_q  (shd_lat[c])
        );

        dcpwm_counter #(.W(W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clr  (cnt_clr[c]),
            .inc  (cnt_inc[c]),
            .cnt_q(cnt_val[c])
        );
    end

    // Event decode
    assign low_nxt   = {1'b0, cnt_val[CH_LOW]} + 1'b1;
    assign next_high = no_low_phase(shd_reg[CH_LOW]);

    always_comb begin
        ev.start   = run_i && (phase_q == PH_STOP);
        ev.step    = run_i && (phase_q != PH_STOP) && tick_i;
        ev.per_hit = ev.step && (cnt_val[CH_PER] == shd_lat[CH_PER]);
        ev.low_hit = ev.step && !ev.per_hit && (phase_q == PH_LOW)
                     && (low_nxt == {1'b0, shd_lat[CH_LOW]});
    end

    // Latch reloads
    assign shd_load[CH_PER] = ev.start || ev.per_hit;
    assign shd_load[CH_LOW] = ev.start || ev.per_hit || ev.low_hit;

    // Counter control: both return to zero at stop, start and period end
    assign cnt_clr[CH_PER] = !run_i || ev.start || ev.per_hit;
    assign cnt_clr[CH_LOW] = !run_i || ev.start || ev.per_hit;
    assign cnt_inc[CH_PER] = ev.step;
    assign cnt_inc[CH_LOW] = ev.step && (phase_q == PH_LOW) && !ev.low_hit;

    // Phase sequencing
    always_comb begin
        phase_d = phase_q;
        if (!run_i) begin
            phase_d = PH_STOP;
        end else if (ev.start || ev.per_hit) begin
            phase_d = next_high ? PH_HIGH : PH_LOW;
        end else if (ev.low_hit) begin
            phase_d = PH_HIGH;
        end
    end

    // Output level: held whenever no event touches it
    always_comb begin
        pwm_d = pwm_q;
        if (ev.start || ev.per_hit) begin
            pwm_d = next_high;
        end else if (ev.low_hit) begin
            pwm_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_STOP;
            pwm_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            pwm_q   <= pwm_d;
        end
    end

    // Match flags and interrupt
    logic [N_CH-1:0] flg_set, flg_clr, flg_en, flg_q;

    assign flg_set[CH_PER] = ev.per_hit;
    assign flg_set[CH_LOW] = ev.low_hit || ((ev.start || ev.per_hit) && next_high);
    assign flg_clr[CH_PER] = per_clr_i;
    assign flg_clr[CH_LOW] = low_clr_i;
    assign flg_en[CH_PER]  = per_ie_i;
    assign flg_en[CH_LOW]  = low_ie_i;

    dcpwm_flags #(.N(N_CH)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (flg_set),
        .clr   (flg_clr),
        .en    (flg_en),
        .flag_q(flg_q),
        .irq   (irq_o)
    );

    assign pwm_o      = pwm_q;
    assign per_flag_o = flg_q[CH_PER];
    assign low_flag_o = flg_q[CH_LOW];

endmodule

// File: rtl/dcpwm_chk.sv
module dcpwm_chk
    import dcpwm_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         per_clr_i,
    input  logic         pwm_o,
    input  logic         per_flag_o,
    input  phase_e       phase,
    input  logic         per_hit,
    input  logic [W-1:0] per_cnt,
    input  logic [W-1:0] low_lat
);

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (run_i && phase != PH_STOP && !tick_i) |=> $stable(pwm_o)); // R1

    AST_HIGH_PHASE_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH) |-> pwm_o); // R2

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $rose(phase != PH_STOP) |-> (pwm_o == (low_lat == '0))); // R3

    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        per_hit |=> (per_cnt == '0 && per_flag_o)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (per_flag_o && !per_clr_i) |=> per_flag_o); // R7

    AST_STOP_HOLDS_OUT: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(pwm_o)); // R9

endmodule

bind dcpwm_top dcpwm_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_i),
    .tick_i    (tick_i),
    .per_clr_i (per_clr_i),
    .pwm_o     (pwm_o),
    .per_flag_o(per_flag_o),
    .phase     (phase_q),
    .per_hit   (ev.per_hit),
    .per_cnt   (cnt_val[dcpwm_pkg::CH_PER]),
    .low_lat   (shd_lat[dcpwm_pkg::CH_LOW])
);

// File: tb/dcpwm_top_bench.sv
`timescale 1ns/1ps
module dcpwm_top_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_i = 1'b0, tick_i = 1'b0;
    logic         per_wr_i = 1'b0, low_wr_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         per_ie_i = 1'b1, low_ie_i = 1'b0;
    logic         per_clr_i = 1'b0, low_clr_i = 1'b0;
    logic         pwm_o, per_flag_o, low_flag_o, irq_o;

    always #2.5 clk = ~clk;   // 200 MHz

    dcpwm_top #(.W(W)) u_dcpwm_top (
        .clk(clk), .rst(rst), .run_i(run_i), .tick_i(tick_i),
        .per_wr_i(per_wr_i), .low_wr_i(low_wr_i), .wr_data_i(wr_data_i),
        .per_ie_i(per_ie_i), .low_ie_i(low_ie_i),
        .per_clr_i(per_clr_i), .low_clr_i(low_clr_i),
        .pwm_o(pwm_o), .per_flag_o(per_flag_o), .low_flag_o(low_flag_o),
        .irq_o(irq_o)
    );

    typedef struct {
        logic  pwm;
        logic  fp;
        logic  fl;
        logic  irq;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Model state: index within the cycle, latched values, data registers
    bit       m_run = 0;
    int       m_k = 0, m_p = 0, m_l = 0;
    int       m_rp = 0, m_rl = 0;
    logic     m_out = 0, m_fp = 0, m_fl = 0;
    bit       run_s = 0;

    // One clock of stimulus; model advanced and expected item pushed
    task automatic cyc(input bit tk, input bit wp, input bit wl, input int d,
                       input bit cp, input bit cl, input string req);
        bit sp, sl;
        run_i = run_s; tick_i = tk; per_wr_i = wp; low_wr_i = wl;
        wr_data_i = W'(d); per_clr_i = cp; low_clr_i = cl;
        @(posedge clk); #1;
        sp = 0; sl = 0;
        if (run_s && !m_run) begin
            m_run = 1; m_k = 0; m_p = m_rp; m_l = m_rl;
            m_out = (m_l == 0);
            sl = (m_l == 0);
        end else if (!run_s) begin
            m_run = 0;
        end else if (tk) begin
            if (m_k == m_p) begin
                m_k = 0; m_p = m_rp; m_l = m_rl;
                sp = 1; sl = (m_l == 0);
            end else begin
                m_k = m_k + 1;
                if (m_k == m_l) sl = 1;
            end
            m_out = (m_k >= m_l);
        end
        m_fp = sp | (m_fp & ~cp);
        m_fl = sl | (m_fl & ~cl);
        if (wp) m_rp = d;
        if (wl) m_rl = d;
        q.push_back('{m_out, m_fp, m_fl, (m_fp & per_ie_i) | (m_fl & low_ie_i), req});
        tick_i = 0; per_wr_i = 0; low_wr_i = 0; per_clr_i = 0; low_clr_i = 0;
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, req);
    endtask

    task automatic idles(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, req);
    endtask

    // Monitor: compares one expected item per clock, away from the edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (pwm_o !== e.pwm || per_flag_o !== e.fp || low_flag_o !== e.fl || irq_o !== e.irq) begin
                n_bad++;
                $display("FAIL %s: got pwm=%b pf=%b lf=%b irq=%b, expected pwm=%b pf=%b lf=%b irq=%b",
                         e.req, pwm_o, per_flag_o, low_flag_o, irq_o, e.pwm, e.fp, e.fl, e.irq);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #3.5;
        // Reset state (R3: output low)
        n_cmp++;
        if (pwm_o !== 0 || per_flag_o !== 0 || low_flag_o !== 0 || irq_o !== 0) begin
            n_bad++;
            $display("FAIL R3 reset: got pwm=%b pf=%b lf=%b irq=%b, expected 0000",
                     pwm_o, per_flag_o, low_flag_o, irq_o);
        end
        @(posedge clk); #1;
        rst = 0;

        cyc(0, 1, 0, 4, 0, 0, "R6");          // period reg = 4
        cyc(0, 0, 1, 2, 0, 0, "R6");          // low reg = 2
        run_s = 1;
        cyc(1, 0, 0, 0, 0, 0, "R10");         // start; tick ignored
        ticks(12, "R2");
        idles(3, "R1");
        for (int i = 0; i < 8; i++) begin
            ticks(1, "R1");
            idles(2, "R1");
        end
        cyc(1, 0, 0, 0, 1, 1, "R7");          // clear alongside a tick
        ticks(6, "R7");
        cyc(1, 0, 0, 0, 1, 1, "R7");
        cyc(0, 0, 1, 0, 0, 0, "R6");          // low = 0 mid-cycle
        ticks(14, "R4");
        cyc(0, 0, 1, 6, 0, 0, "R6");          // low > period
        ticks(14, "R5");
        cyc(0, 0, 1, 4, 0, 0, "R6");          // low == period
        ticks(12, "R2");
        cyc(1, 1, 0, 9, 0, 0, "R6");          // longer period, mid-cycle
        cyc(1, 0, 1, 3, 0, 0, "R6");
        ticks(28, "R6");
        run_s = 0;
        ticks(4, "R9");
        idles(2, "R9");
        cyc(0, 1, 0, 5, 0, 0, "R9");
        cyc(0, 0, 1, 1, 1, 1, "R9");
        per_ie_i = 0; low_ie_i = 1;           // R8 enable swap
        run_s = 1;
        cyc(1, 0, 0, 0, 0, 0, "R10");
        ticks(14, "R8");
        cyc(0, 0, 0, 0, 0, 1, "R8");
        ticks(4, "R8");
        cyc(0, 1, 0, 0, 0, 0, "R5");          // period 0, low 1
        ticks(8, "R5");
        cyc(0, 0, 1, 0, 0, 0, "R4");          // period 0, low 0
        ticks(6, "R4");
        run_s = 0;
        idles(2, "R9");
        run_s = 1;
        cyc(0, 0, 0, 0, 1, 1, "R10");
        ticks(5, "R10");

        wait (q.size() == 0);
        @(posedge clk); #3;
        finish_run();
    end

endmodule